// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block holds the time and date as seven packed-BCD bytes: seconds, minutes, hours, weekday, date, month and a two-digit year. A one-cycle pulse on `tick_i` arrives once per second from an outside divider. Each pulse advances the seconds. Carries ripple through minutes and hours, and from hours to the weekday and the date. From the date the carry goes to the month and then to the year.

The last date of each month is decoded from the current month and year, and a year is treated as a leap year when its BCD value is a multiple of four. Bit 7 of the seconds byte is a halt flag. While it is set, ticks are ignored, and the flag is read back on `sec_o[7]`. A load strobe replaces all seven bytes in one cycle, and software sets or clears the halt flag through this strobe. Bits that no field uses are forced to zero on load and always read as zero.

Top module: `bcd_calendar`

## Requirements
- R1: After an active-low reset the outputs are 00 seconds (halt flag 0), 00 minutes, 00 hours, weekday 01, date 01, month 01 and year 00.
- R2: With the halt flag clear, each tick advances the seconds by one in BCD. Seconds go from 59 to 00 and advance the minutes, and minutes go from 59 to 00 and advance the hours.
- R3: Hours count 00 to 23. When 23 rolls over to 00, the weekday and the date both advance.
- R4: The weekday counts 01 to 07 and wraps to 01 at midnight, independently of the date.
- R5: The date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R6: In month 02 the date wraps after 29 when the BCD year is a multiple of four, and after 28 otherwise.
- R7: Month 12 rolls over to 01 and advances the year. Year 99 rolls over to 00.
- R8: `sec_o[7]` is the halt flag. While it is 1, ticks change no output.
- R9: Once a load clears the halt flag, the next tick advances the seconds again.
- R10: When `load_i` is high, all seven bytes take the `ld_*_i` values at the next clock edge. A tick in the same cycle is ignored.
- R11: Unused bits read as zero, even when the load value has them set: `min_o[7]`, `hour_o[7:6]`, `wday_o[7:3]`, `date_o[7:6]` and `month_o[7:5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse |
| load_i | input | 1 | Load strobe for all fields |
| ld_sec_i | input | 8 | Load value: bit 7 is the halt flag, bits 6:0 are BCD seconds |
| ld_min_i | input | 8 | Load value for minutes |
| ld_hour_i | input | 8 | Load value for hours |
| ld_wday_i | input | 8 | Load value for weekday |
| ld_date_i | input | 8 | Load value for date |
| ld_month_i | input | 8 | Load value for month |
| ld_year_i | input | 8 | Load value for year |
| sec_o | output | 8 | Halt flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| wday_o | output | 8 | BCD weekday |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The bench loads times that sit just before the end of a month. These include the last second of a year, the end of February in years 00, 12, 16, 23 and 24, and the ends of the 30-day months. A design with a wrong month-length table or leap test would step to a 29th, 30th or 31st that does not exist, or skip 29 February. A tens-digit carry bug would show up as a hex value such as 0x5A. The bench also runs ticks while halted, a tick in the same cycle as a load, and loads that have unused bits set. A design that got these wrong would drift while halted, add one to the loaded value, or leak stray high bits.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NFIELDS = 7;

  // field index: 0 sec, 1 min, 2 hour, 3 wday, 4 date, 5 month, 6 year
  localparam logic [BYTE_W-1:0] FIELD_MIN  [NFIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
  localparam logic [BYTE_W-1:0] FIELD_MAX  [NFIELDS] =
    '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};
  localparam logic [BYTE_W-1:0] FIELD_KEEP [NFIELDS] =
    '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
  // source of each field's increment: -1 = gated tick
  localparam int FIELD_SRC [NFIELDS] = '{-1, 0, 1, 2, 2, 4, 5};
  localparam int DATE_IDX = 4;

  function automatic logic bcd_leap(input logic [BYTE_W-1:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [BYTE_W-1:0] month_i,
  input  logic [BYTE_W-1:0] year_i,
  output logic [BYTE_W-1:0] last_date_o
);
  always_comb begin
    unique case (month_i)
      8'h02:                      last_date_o = bcd_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
      default:                    last_date_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MIN_VAL = 8'h00,
  parameter logic [BYTE_W-1:0] KEEP    = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] ld_val_i,
  input  logic [BYTE_W-1:0] max_i,
  output logic [BYTE_W-1:0] val_o,
  output logic              carry_o
);
  logic [BYTE_W-1:0] val_q, val_inc;

  always_comb begin
    if (val_q[3:0] >= 4'd9) val_inc = {val_q[7:4] + 4'd1, 4'd0};
    else                    val_inc = {val_q[7:4], val_q[3:0] + 4'd1};
  end

  // >= so that a loaded out-of-range value still wraps
  assign carry_o = inc_i && (val_q >= max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= MIN_VAL;
    else if (load_i)  val_q <= ld_val_i & KEEP;
    else if (carry_o) val_q <= MIN_VAL;
    else if (inc_i)   val_q <= val_inc & KEEP;
  end

  assign val_o = val_q;

  // R2 R3 R4 R7
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && val_q == max_i) |=> val_q == MIN_VAL);
  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && val_q < max_i) |=> val_q != $past(val_q));
  // R10
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> val_q == ($past(ld_val_i) & KEEP));
  // R11
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_q & ~KEEP) == '0);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] ld_sec_i,
  input  logic [BYTE_W-1:0] ld_min_i,
  input  logic [BYTE_W-1:0] ld_hour_i,
  input  logic [BYTE_W-1:0] ld_wday_i,
  input  logic [BYTE_W-1:0] ld_date_i,
  input  logic [BYTE_W-1:0] ld_month_i,
  input  logic [BYTE_W-1:0] ld_year_i,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic [BYTE_W-1:0] wday_o,
  output logic [BYTE_W-1:0] date_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] year_o
);
  logic [BYTE_W-1:0] ld_val [NFIELDS];
  logic [BYTE_W-1:0] fval   [NFIELDS];
  logic [NFIELDS-1:0] carry, inc;
  logic [BYTE_W-1:0] last_date;
  logic stop_q, tick_run;

  assign ld_val[0] = ld_sec_i;
  assign ld_val[1] = ld_min_i;
  assign ld_val[2] = ld_hour_i;
  assign ld_val[3] = ld_wday_i;
  assign ld_val[4] = ld_date_i;
  assign ld_val[5] = ld_month_i;
  assign ld_val[6] = ld_year_i;

  // R8 halt flag lives beside the seconds digits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stop_q <= 1'b0;
    else if (load_i) stop_q <= ld_sec_i[7];
  end

  assign tick_run = tick_i && !stop_q && !load_i;

  cal_month_len i_month_len (
    .month_i     (fval[5]),
    .year_i      (fval[6]),
    .last_date_o (last_date)
  );

  for (genvar i = 0; i < NFIELDS; i++) begin : g_field
    logic [BYTE_W-1:0] max_sel;
    if (FIELD_SRC[i] < 0) begin : g_root
      assign inc[i] = tick_run;
    end else begin : g_chain
      assign inc[i] = carry[FIELD_SRC[i]];
    end
    if (i == DATE_IDX) begin : g_dyn
      assign max_sel = last_date;
    end else begin : g_fix
      assign max_sel = FIELD_MAX[i];
    end
    cal_bcd_field #(
      .MIN_VAL (FIELD_MIN[i]),
      .KEEP    (FIELD_KEEP[i])
    ) i_field (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (inc[i]),
      .load_i   (load_i),
      .ld_val_i (ld_val[i]),
      .max_i    (max_sel),
      .val_o    (fval[i]),
      .carry_o  (carry[i])
    );
  end

  assign sec_o   = {stop_q, fval[0][6:0]};
  assign min_o   = fval[1];
  assign hour_o  = fval[2];
  assign wday_o  = fval[3];
  assign date_o  = fval[4];
  assign month_o = fval[5];
  assign year_o  = fval[6];

  // R8
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !load_i) |=> $stable({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o}));
  // R6
  feb_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_run && month_o == 8'h02 && date_o == 8'h29 && hour_o == 8'h23
     && min_o == 8'h59 && sec_o[6:0] == 7'h59) |=> date_o == 8'h01 && month_o == 8'h03);
  // R10
  load_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sec_o == $past(ld_sec_i));
  // R4
  wday_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc[3] && wday_o == 8'h07) |=> wday_o == 8'h01);
endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, load = 1'b0;
  logic [7:0] l_sec = 0, l_min = 0, l_hour = 0, l_wday = 0, l_date = 0, l_mon = 0, l_year = 0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;
  int n_run = 0, n_fail = 0;
  int m_stop, m_s, m_mi, m_h, m_wd, m_d, m_mo, m_y;

  always #4 clk = ~clk;

  bcd_calendar i_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .load_i(load),
    .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hour), .ld_wday_i(l_wday),
    .ld_date_i(l_date), .ld_month_i(l_mon), .ld_year_i(l_year),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o));

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] expv();
    return {1'(m_stop), to_bcd(m_s)[6:0], to_bcd(m_mi), to_bcd(m_h), to_bcd(m_wd),
            to_bcd(m_d), to_bcd(m_mo), to_bcd(m_y)};
  endfunction

  task automatic model_step();
    if (m_stop != 0) return;
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_wd = (m_wd == 7) ? 1 : m_wd + 1;
          m_d++;
          if (m_d > dim(m_mo, m_y)) begin
            m_d = 1; m_mo++;
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(input string tag);
    logic [55:0] got;
    got = {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};
    n_run++;
    if (got !== expv()) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, expv());
    end
  endtask

  task automatic do_load(input int st, s, mi, h, wd, d, mo, y, input bit with_tick);
    @(negedge clk);
    l_sec = {1'(st), to_bcd(s)[6:0]}; l_min = to_bcd(mi); l_hour = to_bcd(h);
    l_wday = to_bcd(wd); l_date = to_bcd(d); l_mon = to_bcd(mo); l_year = to_bcd(y);
    load = 1'b1; tick = with_tick;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
    m_stop = st; m_s = s; m_mi = mi; m_h = h; m_wd = wd; m_d = d; m_mo = mo; m_y = y;
  endtask

  task automatic do_tick(input string tag);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    model_step();
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1BCD;
    void'($urandom(seed));
    m_stop = 0; m_s = 0; m_mi = 0; m_h = 0; m_wd = 1; m_d = 1; m_mo = 1; m_y = 0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release");
    do_tick("R2 first tick");

    do_load(0, 59, 59, 23, 7, 31, 12, 99, 0); check("R10 load");
    do_tick("R7 year 99 to 00, R4 wday 07 to 01");
    do_load(0, 59, 59, 12, 3, 14, 5, 40, 0); do_tick("R2 minute and hour carry");
    do_load(0, 59, 59, 23, 5, 30, 4, 10, 0); do_tick("R5 30-day month");
    do_load(0, 59, 59, 23, 5, 30, 7, 10, 0); do_tick("R5 31-day month no wrap");
    do_load(0, 59, 59, 23, 2, 31, 8, 10, 0); do_tick("R5 31-day month wrap");
    do_load(0, 59, 59, 23, 1, 28, 2, 24, 0); do_tick("R6 leap 24 day 29");
    do_load(0, 59, 59, 23, 1, 29, 2, 24, 0); do_tick("R6 leap 24 wrap");
    do_load(0, 59, 59, 23, 1, 28, 2, 23, 0); do_tick("R6 non-leap 23 wrap");
    do_load(0, 59, 59, 23, 1, 28, 2, 0, 0);  do_tick("R6 leap 00");
    do_load(0, 59, 59, 23, 1, 28, 2, 12, 0); do_tick("R6 leap 12");
    do_load(0, 59, 59, 23, 1, 28, 2, 16, 0); do_tick("R6 leap 16");
    do_load(0, 59, 59, 23, 1, 28, 2, 18, 0); do_tick("R6 non-leap 18");
    do_load(0, 59, 59, 23, 6, 10, 3, 50, 0); do_tick("R3 hour 23 wraps, R4 wday 06 to 07");

    do_load(1, 30, 10, 5, 2, 9, 9, 9, 0); check("R8 halt loaded");
    for (int k = 0; k < 5; k++) do_tick("R8 halted tick ignored");
    do_load(0, 30, 10, 5, 2, 9, 9, 9, 0); do_tick("R9 resume after clear");

    do_load(0, 45, 1, 2, 3, 4, 5, 6, 1); check("R10 load beats tick");

    @(negedge clk);
    l_sec = 8'h12; l_min = 8'hB4; l_hour = 8'hC5; l_wday = 8'hFB;
    l_date = 8'hD3; l_mon = 8'hE9; l_year = 8'h77; load = 1'b1;
    @(negedge clk); load = 1'b0;
    m_stop = 0; m_s = 12; m_mi = 34; m_h = 5; m_wd = 3; m_d = 13; m_mo = 9; m_y = 77;
    check("R11 unused bits masked");

    for (int t = 0; t < 300; t++) begin
      int s, mi, h, wd, mo, y, d, nt;
      s  = ($urandom % 2 != 0) ? 57 + ($urandom % 3) : $urandom % 60;
      mi = ($urandom % 2 != 0) ? 59 : $urandom % 60;
      h  = ($urandom % 2 != 0) ? 23 : $urandom % 24;
      wd = 1 + $urandom % 7;
      mo = 1 + $urandom % 12;
      y  = ($urandom % 4 == 0) ? 99 : $urandom % 100;
      d  = ($urandom % 2 != 0) ? dim(mo, y) - ($urandom % 2) : 1 + $urandom % dim(mo, y);
      do_load(0, s, mi, h, wd, d, mo, y, 0);
      nt = 1 + $urandom % 8;
      for (int k = 0; k < nt; k++) do_tick("R2 R3 R5 R7 random rollover");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule